// File: doc/BRIEF.md
# Microcoded Execution Datapath

This block is the execution datapath of a small horizontally microcoded 32-bit processor. It has one A-side operand, the holding register, and a B bus that carries one of nine readable registers. The B-bus sources include an 8-bit byte register, which can be read sign-extended or zero-extended. The ALU applies one of a fixed set of operations. A shifter can then move the ALU result left by a byte or right by one bit. The shifted value goes onto the C bus, and any subset of nine destination registers loads it at the same clock edge.

The micro-instruction fields arrive on the ports every cycle and are applied at the next rising edge. These fields are: the B source, the ALU operation, the shift control, the destination mask and the flag-latch request. Negative and zero status is taken from the ALU output before the shifter, and it is latched on request for a later conditional branch. Two load ports let the memory side place a read word into the memory-data register and a fetched byte into the byte register. The result of every micro-instruction is also held in a result register.

Top module: `uc_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, all ten registers are cleared to zero. This covers the nine destinations and the byte register, and also the result register, both latched flags and the shift error flag.
- R2: `b_sel` chooses the B bus as follows: 0 memory data, 1 program counter, 2 byte signed, 3 byte unsigned, 4 stack pointer, 5 frame base, 6 pool base, 7 stack top, 8 scratch. Codes 9 to 15 put zero on the B bus.
- R3: Code 2 presents the byte register sign-extended to 32 bits, and code 3 presents it zero-extended.
- R4: The ALU uses the holding register as A and computes, by `alu_op` code:
  - 0 A&B, 1 A|B, 2 ~A, 3 ~B
  - 4 A+B, 5 A+B+1, 6 A+1, 7 B+1
  - 8 B-A, 9 -A, 10 B-1
  - 11 zero, 12 one, 13 all-ones
  - 14 and 15 yield zero.

  All arithmetic is modulo 2^32.
- R5: `shift_sel` 0 passes the ALU value through. Code 1 shifts it left by 8 with zero fill. Code 2 shifts it right by 1 arithmetically, so bit 31 is replicated.
- R6: `shift_sel` 3 is illegal. The C bus then carries the unshifted ALU value, and `shift_err_o` is 1 for that micro-instruction; it is 0 after every legal one.
- R7: `c_wr_en` bits select the destinations loaded from the C bus: bit 0 memory address, bit 1 memory data, bit 2 program counter, bit 3 stack pointer, bit 4 frame base, bit 5 pool base, bit 6 stack top, bit 7 scratch, bit 8 holding. Destinations whose bit is 0 keep their value.
- R8: When `flag_ld` is 1, `flag_n_o` latches bit 31 of the ALU output and `flag_z_o` latches whether all 32 ALU output bits are zero, both taken before the shifter. When `flag_ld` is 0, both flags hold their value.
- R9: A register that is read and written in the same micro-instruction supplies its old value, and it holds the new value from the next micro-instruction on.
- R10: `mem_rd_valid` loads `mem_rd_data` into memory data, and `byte_ld` loads `byte_in` into the byte register. When bit 1 of `c_wr_en` is set in the same cycle, the C bus wins.
- R11: `result_o` shows the C-bus value of the micro-instruction applied at the previous rising edge. `mem_addr_o`, `mem_wdata_o` and `prog_ctr_o` show their registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| b_sel | input | 4 | B bus source code |
| alu_op | input | 4 | ALU operation code |
| shift_sel | input | 2 | Shifter control |
| c_wr_en | input | 9 | Destination load mask |
| flag_ld | input | 1 | Latch N and Z this cycle |
| mem_rd_valid | input | 1 | Load memory data from mem_rd_data |
| mem_rd_data | input | 32 | Word returned by memory |
| byte_ld | input | 1 | Load the byte register |
| byte_in | input | 8 | Fetched byte |
| result_o | output | 32 | Registered C bus value |
| flag_n_o | output | 1 | Latched negative flag |
| flag_z_o | output | 1 | Latched zero flag |
| shift_err_o | output | 1 | Illegal shift code seen |
| mem_addr_o | output | 32 | Memory address register |
| mem_wdata_o | output | 32 | Memory data register |
| prog_ctr_o | output | 32 | Program counter register |

## Verification
Every micro-instruction's result reaches `result_o` one edge later, so a wrong ALU operation, extension or shift shows up on the very next cycle. A register loaded with a wrong value, or one disturbed by a write it should not take, stays hidden until some later micro-instruction drives it onto the B bus. The bench therefore reads every destination back after the writes that touch it. A wrong flag appears on the latched outputs one cycle after the request, or as a change while latching is off.

// File: rtl/uc_dp_pkg.sv
package uc_dp_pkg;
  localparam int DP_W     = 32;
  localparam int DP_BYTE  = 8;
  localparam int NUM_DST  = 9;
  localparam int BSEL_W   = 4;
  localparam int OP_W     = 4;

  // destination indices (bit positions of the load mask)
  localparam int DST_MADDR   = 0;
  localparam int DST_MDATA   = 1;
  localparam int DST_PCTR    = 2;
  localparam int DST_SPTR    = 3;
  localparam int DST_FRAME   = 4;
  localparam int DST_POOL    = 5;
  localparam int DST_TOP     = 6;
  localparam int DST_SCRATCH = 7;
  localparam int DST_HOLD    = 8;

  typedef enum logic [BSEL_W-1:0] {
    SRC_MDATA   = 4'd0,
    SRC_PCTR    = 4'd1,
    SRC_BYTE_S  = 4'd2,
    SRC_BYTE_U  = 4'd3,
    SRC_SPTR    = 4'd4,
    SRC_FRAME   = 4'd5,
    SRC_POOL    = 4'd6,
    SRC_TOP     = 4'd7,
    SRC_SCRATCH = 4'd8
  } bsrc_e;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_NOTA = 4'd2,
    OP_NOTB = 4'd3,
    OP_ADD  = 4'd4,
    OP_ADD1 = 4'd5,
    OP_INCA = 4'd6,
    OP_INCB = 4'd7,
    OP_SUB  = 4'd8,
    OP_NEGA = 4'd9,
    OP_DECB = 4'd10,
    OP_ZERO = 4'd11,
    OP_ONE  = 4'd12,
    OP_MONE = 4'd13
  } aluop_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_LEFT = 2'd1,
    SH_RGHT = 2'd2,
    SH_BAD  = 2'd3
  } shift_e;
endpackage

// File: rtl/uc_bsrc_mux.sv
module uc_bsrc_mux
  import uc_dp_pkg::*;
#(
  parameter int DATA_W = DP_W,
  parameter int BYTE_W = DP_BYTE,
  parameter int NDST   = NUM_DST
) (
  input  logic [BSEL_W-1:0] sel,
  input  logic [DATA_W-1:0] regs [NDST],
  input  logic [BYTE_W-1:0] byte_q,
  output logic [DATA_W-1:0] b_bus
);
  localparam int EXT_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] byte_sx;
  logic [DATA_W-1:0] byte_zx;

  assign byte_sx = {{EXT_W{byte_q[BYTE_W-1]}}, byte_q};
  assign byte_zx = {{EXT_W{1'b0}}, byte_q};

  always_comb begin
    b_bus = '0;
    case (sel)
      SRC_MDATA:   b_bus = regs[DST_MDATA];
      SRC_PCTR:    b_bus = regs[DST_PCTR];
      SRC_BYTE_S:  b_bus = byte_sx;
      SRC_BYTE_U:  b_bus = byte_zx;
      SRC_SPTR:    b_bus = regs[DST_SPTR];
      SRC_FRAME:   b_bus = regs[DST_FRAME];
      SRC_POOL:    b_bus = regs[DST_POOL];
      SRC_TOP:     b_bus = regs[DST_TOP];
      SRC_SCRATCH: b_bus = regs[DST_SCRATCH];
      default:     b_bus = '0;
    endcase
  end
endmodule

// File: rtl/uc_alu.sv
module uc_alu
  import uc_dp_pkg::*;
#(
  parameter int DATA_W = DP_W
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              neg,
  output logic              zero
);
  localparam logic [DATA_W-1:0] ONE_V = DATA_W'(1);

  always_comb begin
    y = '0;
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_NOTA: y = ~a;
      OP_NOTB: y = ~b;
      OP_ADD:  y = a + b;
      OP_ADD1: y = a + b + ONE_V;
      OP_INCA: y = a + ONE_V;
      OP_INCB: y = b + ONE_V;
      OP_SUB:  y = b - a;
      OP_NEGA: y = '0 - a;
      OP_DECB: y = b - ONE_V;
      OP_ZERO: y = '0;
      OP_ONE:  y = ONE_V;
      OP_MONE: y = '1;
      default: y = '0;
    endcase
  end

  assign neg  = y[DATA_W-1];
  assign zero = (y == '0);
endmodule

// File: rtl/uc_shifter.sv
module uc_shifter
  import uc_dp_pkg::*;
#(
  parameter int DATA_W    = DP_W,
  parameter int SHL_AMT   = DP_BYTE,
  parameter bit ARITH_SHR = 1'b1
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              illegal
);
  logic [DATA_W-1:0] shr_v;
  logic [DATA_W-1:0] shl_v;

  assign shl_v = din << SHL_AMT;

  generate
    if (ARITH_SHR) begin : g_arith
      assign shr_v = {din[DATA_W-1], din[DATA_W-1:1]};
    end else begin : g_logic
      assign shr_v = {1'b0, din[DATA_W-1:1]};
    end
  endgenerate

  always_comb begin
    illegal = 1'b0;
    case (sel)
      SH_LEFT: dout = shl_v;
      SH_RGHT: dout = shr_v;
      SH_BAD: begin
        dout    = din;
        illegal = 1'b1;
      end
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/uc_datapath.sv
module uc_datapath
  import uc_dp_pkg::*;
#(
  parameter int DATA_W = DP_W,
  parameter int BYTE_W = DP_BYTE,
  parameter int NDST   = NUM_DST
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        b_sel,
  input  logic [3:0]        alu_op,
  input  logic [1:0]        shift_sel,
  input  logic [NDST-1:0]   c_wr_en,
  input  logic              flag_ld,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              byte_ld,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              shift_err_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] prog_ctr_o
);
  logic [DATA_W-1:0] regs_q [NDST];
  logic [BYTE_W-1:0] byte_q;
  logic [DATA_W-1:0] b_bus;
  logic [DATA_W-1:0] alu_y;
  logic              alu_n;
  logic              alu_z;
  logic [DATA_W-1:0] c_bus;
  logic              sh_bad;

  uc_bsrc_mux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NDST(NDST)) u_bmux (
    .sel    (b_sel),
    .regs   (regs_q),
    .byte_q (byte_q),
    .b_bus  (b_bus)
  );

  uc_alu #(.DATA_W(DATA_W)) u_alu (
    .op   (alu_op),
    .a    (regs_q[DST_HOLD]),
    .b    (b_bus),
    .y    (alu_y),
    .neg  (alu_n),
    .zero (alu_z)
  );

  uc_shifter #(.DATA_W(DATA_W), .SHL_AMT(BYTE_W), .ARITH_SHR(1'b1)) u_shift (
    .sel     (shift_sel),
    .din     (alu_y),
    .dout    (c_bus),
    .illegal (sh_bad)
  );

  // destination registers: C bus has priority over the memory load port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NDST; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NDST; i++) begin
        if (c_wr_en[i]) regs_q[i] <= c_bus;
        else if (i == DST_MDATA && mem_rd_valid) regs_q[i] <= mem_rd_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          byte_q <= '0;
    else if (byte_ld) byte_q <= byte_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o    <= '0;
      shift_err_o <= 1'b0;
      flag_n_o    <= 1'b0;
      flag_z_o    <= 1'b0;
    end else begin
      result_o    <= c_bus;
      shift_err_o <= sh_bad;
      if (flag_ld) begin
        flag_n_o <= alu_n;
        flag_z_o <= alu_z;
      end
    end
  end

  assign mem_addr_o  = regs_q[DST_MADDR];
  assign mem_wdata_o = regs_q[DST_MDATA];
  assign prog_ctr_o  = regs_q[DST_PCTR];

  // R6: illegal shift passes the ALU value and raises the error flag
  a_r6_bad_shift_passes: assert property (@(posedge clk) disable iff (rst)
    (shift_sel == 2'b11) |=> (shift_err_o && result_o == $past(alu_y)));

  // R5: left shift clears the low byte of the result
  a_r5_left_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (shift_sel == 2'b01) |=> (result_o[BYTE_W-1:0] == '0));

  // R8: flags hold while latching is off
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !flag_ld |=> ($stable(flag_n_o) && $stable(flag_z_o)));

  // R8: zero flag follows the pre-shift ALU value
  a_r8_zero_preshift: assert property (@(posedge clk) disable iff (rst)
    flag_ld |=> (flag_z_o == ($past(alu_y) == '0)));

  // R7: unselected address register keeps its value
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !c_wr_en[DST_MADDR] |=> $stable(mem_addr_o));

  // R3: unsigned byte view has zero upper bits on the B bus
  a_r3_byte_unsigned: assert property (@(posedge clk) disable iff (rst)
    (b_sel == 4'd3) |-> (b_bus[DATA_W-1:BYTE_W] == '0));
endmodule

// File: tb/tb_uc_datapath.sv
`timescale 1ns/1ps
module tb_uc_datapath;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    b_sel = '0;
  logic [3:0]    alu_op = 4'd11;
  logic [1:0]    shift_sel = '0;
  logic [8:0]    c_wr_en = '0;
  logic          flag_ld = 1'b0;
  logic          mem_rd_valid = 1'b0;
  logic [W-1:0]  mem_rd_data = '0;
  logic          byte_ld = 1'b0;
  logic [7:0]    byte_in = '0;
  logic [W-1:0]  result_o, mem_addr_o, mem_wdata_o, prog_ctr_o;
  logic          flag_n_o, flag_z_o, shift_err_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uc_datapath dut (
    .clk(clk), .rst(rst), .b_sel(b_sel), .alu_op(alu_op), .shift_sel(shift_sel),
    .c_wr_en(c_wr_en), .flag_ld(flag_ld), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .byte_ld(byte_ld), .byte_in(byte_in),
    .result_o(result_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
    .shift_err_o(shift_err_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .prog_ctr_o(prog_ctr_o)
  );

  typedef struct {
    logic [W-1:0] res;
    logic         n, z, err;
    logic [W-1:0] mar, mdr, pc;
    string        tag;
  } exp_t;

  exp_t sbq[$];

  // bench model of architectural state
  logic [W-1:0] m_reg [9];
  logic [7:0]   m_byte;
  logic         m_n, m_z;

  function automatic logic [W-1:0] src_val(int s);
    case (s)
      0: return m_reg[1];
      1: return m_reg[2];
      2: return {{24{m_byte[7]}}, m_byte};
      3: return {24'd0, m_byte};
      4: return m_reg[3];
      5: return m_reg[4];
      6: return m_reg[5];
      7: return m_reg[6];
      8: return m_reg[7];
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] alu_val(int op, logic [W-1:0] a, logic [W-1:0] b);
    case (op)
      0: return a & b;
      1: return a | b;
      2: return ~a;
      3: return ~b;
      4: return a + b;
      5: return a + b + 1;
      6: return a + 1;
      7: return b + 1;
      8: return b - a;
      9: return -a;
      10: return b - 1;
      12: return 32'd1;
      13: return 32'hFFFF_FFFF;
      default: return '0;
    endcase
  endfunction

  task automatic step(int bs, int op, int sh, logic [8:0] wen, logic fld,
                      logic mrv, logic [W-1:0] mrd, logic bl, logic [7:0] bin,
                      string tag);
    exp_t e;
    logic [W-1:0] y, c;
    @(negedge clk);
    b_sel = 4'(bs); alu_op = 4'(op); shift_sel = 2'(sh); c_wr_en = wen;
    flag_ld = fld; mem_rd_valid = mrv; mem_rd_data = mrd; byte_ld = bl; byte_in = bin;
    y = alu_val(op, m_reg[8], src_val(bs));
    case (sh)
      1: c = y << 8;
      2: c = {y[W-1], y[W-1:1]};
      default: c = y;
    endcase
    if (fld) begin m_n = y[W-1]; m_z = (y == '0); end
    for (int i = 0; i < 9; i++) begin
      if (wen[i]) m_reg[i] = c;
      else if (i == 1 && mrv) m_reg[i] = mrd;
    end
    if (bl) m_byte = bin;
    e.res = c; e.n = m_n; e.z = m_z; e.err = (sh == 3);
    e.mar = m_reg[0]; e.mdr = m_reg[1]; e.pc = m_reg[2]; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    c_wr_en = '0; flag_ld = 1'b0; mem_rd_valid = 1'b0; byte_ld = 1'b0;
    shift_sel = '0; alu_op = 4'd11; b_sel = '0;
  endtask

  task automatic cmp(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compares each queued expectation after its edge
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      cmp(e.tag, "result", result_o, e.res);
      cmp(e.tag, "flag_n", W'(flag_n_o), W'(e.n));
      cmp(e.tag, "flag_z", W'(flag_z_o), W'(e.z));
      cmp(e.tag, "shift_err", W'(shift_err_o), W'(e.err));
      cmp(e.tag, "mem_addr", mem_addr_o, e.mar);
      cmp(e.tag, "mem_wdata", mem_wdata_o, e.mdr);
      cmp(e.tag, "prog_ctr", prog_ctr_o, e.pc);
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) m_reg[i] = '0;
    m_byte = '0; m_n = 1'b0; m_z = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    cmp("R1", "result", result_o, '0);
    cmp("R1", "flags", W'({flag_n_o, flag_z_o, shift_err_o}), '0);
    cmp("R1", "mem_addr", mem_addr_o, '0);
    cmp("R1", "prog_ctr", prog_ctr_o, '0);

    // R10: memory load port and byte load
    step(0, 11, 0, 9'h000, 0, 1, 32'h1234_5678, 1, 8'h9C, "R10");
    // R7: one C value into several destinations (pc, sp, addr)
    step(0, 4, 0, 9'h00D, 1, 0, 0, 0, 0, "R7");
    // R3: signed and unsigned byte views
    step(2, 4, 0, 9'h040, 1, 0, 0, 0, 0, "R3");
    step(3, 4, 0, 9'h080, 1, 0, 0, 0, 0, "R3");
    // load holding register
    step(0, 4, 0, 9'h100, 0, 0, 0, 0, 0, "R7");
    step(0, 11, 0, 9'h000, 0, 1, 32'h0000_0F00, 0, 0, "R10");
    // R4/R8: every operation code with flags latched
    for (int op = 0; op < 16; op++) step(0, op, 0, 9'h000, 1, 0, 0, 0, 0, "R4");
    // R5: shifts
    step(8, 12, 1, 9'h000, 1, 0, 0, 0, 0, "R5");
    step(8, 13, 2, 9'h000, 1, 0, 0, 0, 0, "R5");
    step(2, 3, 2, 9'h000, 1, 0, 0, 0, 0, "R5");
    step(8, 13, 1, 9'h000, 1, 0, 0, 0, 0, "R5");
    // R8: Z taken before shifter (one shifted right becomes zero)
    step(8, 12, 2, 9'h000, 1, 0, 0, 0, 0, "R8");
    // R6: illegal shift code
    step(0, 9, 3, 9'h000, 1, 0, 0, 0, 0, "R6");
    step(0, 9, 0, 9'h000, 0, 0, 0, 0, 0, "R6");
    // R8: flags hold when not latched
    step(8, 11, 0, 9'h000, 0, 0, 0, 0, 0, "R8");
    step(8, 13, 0, 9'h000, 0, 0, 0, 0, 0, "R8");
    // R9: read-modify-write of stack pointer
    step(4, 7, 0, 9'h008, 0, 0, 0, 0, 0, "R9");
    step(4, 7, 0, 9'h008, 0, 0, 0, 0, 0, "R9");
    step(1, 10, 0, 9'h004, 0, 0, 0, 0, 0, "R9");
    // R10: C bus beats memory load into memory data
    step(4, 4, 0, 9'h002, 0, 1, 32'hDEAD_BEEF, 0, 0, "R10");
    step(0, 4, 0, 9'h000, 0, 0, 0, 0, 0, "R10");
    // R2: unused source codes read zero
    for (int s = 9; s < 16; s++) step(s, 4, 0, 9'h000, 1, 0, 0, 0, 0, "R2");
    // R7: write frame and pool, read back every B source
    step(7, 1, 0, 9'h010, 0, 0, 0, 0, 0, "R7");
    step(8, 8, 0, 9'h020, 0, 0, 0, 0, 0, "R7");
    for (int s = 0; s < 9; s++) step(s, 3, 0, 9'h000, 1, 0, 0, 0, 0, "R2");
    // R11: result register follows each micro-instruction
    step(6, 5, 1, 9'h001, 1, 0, 0, 0, 0, "R11");
    step(5, 6, 2, 9'h000, 1, 0, 0, 0, 0, "R11");
    idle();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule